// File: doc/BRIEF.md
# Serial Port Register and Interrupt Block

This block is the register file and interrupt logic of a simple serial port. A host reaches it through a word-indexed read/write port. On the line side it takes received characters, with a separate break indication, into a single-character holding register. It hands transmitted bytes to a serialiser through a valid/ready handshake. Baud generation, bit timing, FIFOs and modem lines are handled elsewhere. The baud, FIFO-control and millisecond registers are plain storage that software can read back.

The block keeps the control words and the two status words. Status flags that report events are cleared by writing ones to them. A control bit that is active low restores the reset state. A single level interrupt is formed each cycle by masking the status flags with enable bits in the control words.

Top module: `uart_reg_block`

## Requirements
- R1: After reset the registers read as follows. Status 1 (index 0x25) is 0x6040 and status 2 (0x26) is 0x4028. The test register (0x2D) is 0x0060. Control 1 (0x20) is 0 and control 2 (0x21) is 0x0001. Control 3 (0x22) is 0x0700. The baud modulator (0x2A) is 0 and the baud count (0x2B) is 4. The receive word (0x00) is 0x4000, which is the error flag in bit 14 with the ready flag clear. All other registers are 0, and irq is low.
- R2: A write to control 1, 3 or 4, FIFO control (0x24), baud incremental (0x29), baud modulator, baud count or the millisecond register (0x2C) stores the low 16 bits and reads back. A write to the test register is ignored. Unmapped indices read 0, and writes to them change nothing.
- R3: Writing control 2 with bit 0 clear restores the R1 values of status 1 and 2, the test register, control 1 and 3, the baud modulator and count, and the receive word. It drops any pending transmit. Control 2 then holds the written value with bit 0 forced to 1. Control 4, FIFO control, baud incremental and the millisecond register keep their values.
- R4: A received character is accepted only while status 1 bit 9 (receive-ready) is clear; rx_ready shows that condition. Acceptance sets status 1 bit 9 and status 2 bit 0 (data-ready), clears test bit 5 (receive-empty) and stores the character zero-extended. Characters offered while full are dropped.
- R5: Reading index 0x00 while the holding register is full returns the stored value with bit 15 set. The same read clears status 1 bit 9 and status 2 bit 0 and sets test bit 5. Reading it while empty returns the stored value with bit 15 clear and changes nothing.
- R6: An accepted break stores 0x5800, which is break (bit 11), frame error (bit 12) and error (bit 14). It also sets status 2 bit 2 (break-detected).
- R7: A write to status 1 clears only the bits of mask 0x9DB0 that are written as 1. Ready, data-sense (bit 6) and RTS-status (bit 14) are unaffected.
- R8: A write to status 2 clears only the bits of mask 0xBDD6 that are written as 1; break-detected is one of them. Data-ready, transmit-done (bit 3), DCD-input (bit 5) and transmit-empty (bit 14) are unaffected.
- R9: A write to transmit data (0x10) is ignored unless control 2 bit 2 is set, and it is also ignored while a byte is pending. An accepted write raises tx_valid with the low byte of the write data. It clears status 1 bit 13 (transmitter-ready) and status 2 bit 3. Both bits are set again in the cycle after tx_ready meets tx_valid, and tx_valid then falls.
- R10: irq is high when status 1 and control 1 share a set bit at position 9 or 13.
- R11: irq is also high when status 2 bit 14 is set with control 1 bit 6, or status 2 bit 3 is set with control 4 bit 3, or status 2 bit 0 is set with control 4 bit 0. In every other case irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 6 | Word index of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data; only the low 16 bits are used |
| rd_en | input | 1 | Read strobe; side effects take place at the clock edge |
| rd_data | output | 32 | Read data for reg_sel while rd_en is high, otherwise 0 |
| rx_valid | input | 1 | A received character or break is offered |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | The offered item is a break condition |
| rx_ready | output | 1 | The holding register can accept an item |
| tx_valid | output | 1 | A transmit byte is pending |
| tx_data | output | 8 | Pending transmit byte |
| tx_ready | input | 1 | Serialiser takes the byte |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest cases to reach are those where two separately owned states meet. One is a soft reset issued while a character is held and enables sit in control 4. Another is a transmit interrupt that must stay low while a byte waits and rise only after the handshake. The bench reaches these with ordered directed sequences: it programs enables, loads the holding register from the line side, parks a byte with tx_ready held low, and only then issues the soft-reset write or the ready pulse. After each step it reads every affected register through the host port.

// File: rtl/uart_reg_pkg.sv
// Package: register indices, bit positions and reset values shared by the
// serial-port register block. Assumes a 6-bit word index and 16-bit registers.
package uart_reg_pkg;
    localparam int REG_W = 16;
    localparam int SEL_W = 6;

    typedef logic [REG_W-1:0] reg_word_t;
    typedef logic [SEL_W-1:0] reg_idx_t;

    localparam reg_idx_t IDX_RXD  = 6'h00;
    localparam reg_idx_t IDX_TXD  = 6'h10;
    localparam reg_idx_t IDX_CR1  = 6'h20;
    localparam reg_idx_t IDX_CR2  = 6'h21;
    localparam reg_idx_t IDX_CR3  = 6'h22;
    localparam reg_idx_t IDX_CR4  = 6'h23;
    localparam reg_idx_t IDX_FCR  = 6'h24;
    localparam reg_idx_t IDX_SR1  = 6'h25;
    localparam reg_idx_t IDX_SR2  = 6'h26;
    localparam reg_idx_t IDX_BINC = 6'h29;
    localparam reg_idx_t IDX_BMOD = 6'h2A;
    localparam reg_idx_t IDX_BCNT = 6'h2B;
    localparam reg_idx_t IDX_MS   = 6'h2C;
    localparam reg_idx_t IDX_TST  = 6'h2D;

    // status 1 / control 1 shared positions
    localparam int S1_RXRDY = 9;
    localparam int S1_TXRDY = 13;
    localparam int S1_DSENS = 6;
    localparam int S1_RTSST = 14;
    localparam int C1_TXEIE = 6;
    // control 2
    localparam int C2_NRST  = 0;
    localparam int C2_TXON  = 2;
    // status 2
    localparam int S2_DRDY  = 0;
    localparam int S2_BRKD  = 2;
    localparam int S2_TXDN  = 3;
    localparam int S2_DCDI  = 5;
    localparam int S2_TXEMP = 14;
    // test register
    localparam int TS_RXEMP = 5;
    localparam int TS_TXEMP = 6;
    // receive word
    localparam int RW_VALID = 15;

    localparam reg_word_t S1_RESET  = 16'h6040;
    localparam reg_word_t S2_RESET  = 16'h4028;
    localparam reg_word_t TS_RESET  = 16'h0060;
    localparam reg_word_t CR2_RESET = 16'h0001;
    localparam reg_word_t CR3_RESET = 16'h0700;
    localparam reg_word_t BCNT_RESET = 16'h0004;
    localparam reg_word_t RXW_RESET = 16'h4000;
    localparam reg_word_t RXW_BREAK = 16'h5800;

    localparam reg_word_t S1_W1C_MASK = 16'h9DB0;
    localparam reg_word_t S2_W1C_MASK = 16'hBDD6;
    localparam reg_word_t S1_IRQ_MASK = reg_word_t'((1 << S1_RXRDY) | (1 << S1_TXRDY));
    localparam reg_word_t C4_IRQ_MASK = reg_word_t'((1 << S2_TXDN) | (1 << S2_DRDY));
endpackage

// File: rtl/uart_ctrl_regs.sv
// Control and plain storage registers. Decodes host writes and produces the
// soft-reset pulse (control 2 written with its active-low bit clear).
// Assumes at most one host access per cycle and 16-bit write data.
module uart_ctrl_regs
    import uart_reg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  reg_idx_t  reg_sel,
    input  reg_word_t wr_word,
    output logic      soft_rst,
    output reg_word_t cr1_q,
    output reg_word_t cr2_q,
    output reg_word_t cr3_q,
    output reg_word_t cr4_q,
    output reg_word_t fcr_q,
    output reg_word_t binc_q,
    output reg_word_t bmod_q,
    output reg_word_t bcnt_q,
    output reg_word_t ms_q
);
    logic wr_cr2;

    // Purpose: detect the soft-reset write.
    always_comb begin
        wr_cr2   = wr_en && (reg_sel == IDX_CR2);
        soft_rst = wr_cr2 && !wr_word[C2_NRST];
    end

    // Purpose: registers cleared only by the hardware reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr4_q  <= '0;
            fcr_q  <= '0;
            binc_q <= '0;
            ms_q   <= '0;
        end else if (wr_en) begin
            if (reg_sel == IDX_CR4)  cr4_q  <= wr_word;
            if (reg_sel == IDX_FCR)  fcr_q  <= wr_word;
            if (reg_sel == IDX_BINC) binc_q <= wr_word;
            if (reg_sel == IDX_MS)   ms_q   <= wr_word;
        end
    end

    // Purpose: registers also restored by the soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr1_q  <= '0;
            cr2_q  <= CR2_RESET;
            cr3_q  <= CR3_RESET;
            bmod_q <= '0;
            bcnt_q <= BCNT_RESET;
        end else if (soft_rst) begin
            cr1_q  <= '0;
            cr2_q  <= wr_word | CR2_RESET;
            cr3_q  <= CR3_RESET;
            bmod_q <= '0;
            bcnt_q <= BCNT_RESET;
        end else if (wr_en) begin
            if (reg_sel == IDX_CR1)  cr1_q  <= wr_word;
            if (wr_cr2)              cr2_q  <= wr_word;
            if (reg_sel == IDX_CR3)  cr3_q  <= wr_word;
            if (reg_sel == IDX_BMOD) bmod_q <= wr_word;
            if (reg_sel == IDX_BCNT) bcnt_q <= wr_word;
        end
    end

    // R3
    srst_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cr2_q[C2_NRST] && cr1_q == '0 && cr3_q == CR3_RESET && bcnt_q == BCNT_RESET));
    // R2
    cr1_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == IDX_CR1) |=> (cr1_q == $past(wr_word)));
endmodule

// File: rtl/uart_status.sv
// Status words, test register, receive holding register and transmit
// handshake. Assumes the line side offers at most one item per cycle and
// that the soft reset overrides every other update in the same cycle.
module uart_status
    import uart_reg_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_idx_t          reg_sel,
    input  reg_word_t         wr_word,
    input  logic              tx_enable,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_break,
    output logic              rx_ready,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    output reg_word_t         sr1_q,
    output reg_word_t         sr2_q,
    output reg_word_t         tst_q,
    output reg_word_t         rxw_q
);
    reg_word_t         sr1_n, sr2_n, tst_n, rxw_n;
    logic              pend_q, pend_n;
    logic [CHAR_W-1:0] txb_q, txb_n;
    logic              rx_take, rx_pop;

    // Purpose: line-side acceptance and host pop of the holding register.
    always_comb begin
        rx_ready = !sr1_q[S1_RXRDY];
        rx_take  = rx_valid && rx_ready;
        rx_pop   = rd_en && (reg_sel == IDX_RXD) && !tst_q[TS_RXEMP];
    end

    // Purpose: next state of every flag, ordered by priority.
    always_comb begin
        sr1_n  = sr1_q;
        sr2_n  = sr2_q;
        tst_n  = tst_q;
        rxw_n  = rxw_q;
        pend_n = pend_q;
        txb_n  = txb_q;
        if (pend_q && tx_ready) begin
            pend_n           = 1'b0;
            sr1_n[S1_TXRDY]  = 1'b1;
            sr2_n[S2_TXDN]   = 1'b1;
        end
        if (wr_en && reg_sel == IDX_TXD && tx_enable && !pend_q) begin
            pend_n           = 1'b1;
            txb_n            = wr_word[CHAR_W-1:0];
            sr1_n[S1_TXRDY]  = 1'b0;
            sr2_n[S2_TXDN]   = 1'b0;
        end
        if (wr_en && reg_sel == IDX_SR1) sr1_n = sr1_n & ~(wr_word & S1_W1C_MASK);
        if (wr_en && reg_sel == IDX_SR2) sr2_n = sr2_n & ~(wr_word & S2_W1C_MASK);
        if (rx_pop) begin
            sr1_n[S1_RXRDY]  = 1'b0;
            sr2_n[S2_DRDY]   = 1'b0;
            tst_n[TS_RXEMP]  = 1'b1;
        end
        if (rx_take) begin
            sr1_n[S1_RXRDY]  = 1'b1;
            sr2_n[S2_DRDY]   = 1'b1;
            tst_n[TS_RXEMP]  = 1'b0;
            rxw_n            = rx_break ? RXW_BREAK : reg_word_t'(rx_data);
            if (rx_break) sr2_n[S2_BRKD] = 1'b1;
        end
    end

    // Purpose: state registers with hardware and soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            sr1_q  <= S1_RESET;
            sr2_q  <= S2_RESET;
            tst_q  <= TS_RESET;
            rxw_q  <= RXW_RESET;
            pend_q <= 1'b0;
            txb_q  <= '0;
        end else begin
            sr1_q  <= sr1_n;
            sr2_q  <= sr2_n;
            tst_q  <= tst_n;
            rxw_q  <= rxw_n;
            pend_q <= pend_n;
            txb_q  <= txb_n;
        end
    end

    assign tx_valid = pend_q;
    assign tx_data  = txb_q;

    // R4
    rx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !soft_rst) |=> (sr1_q[S1_RXRDY] && sr2_q[S2_DRDY] && !tst_q[TS_RXEMP]));
    // R5
    rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel == IDX_RXD && sr1_q[S1_RXRDY] && !soft_rst) |=> (!sr1_q[S1_RXRDY] && tst_q[TS_RXEMP]));
    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !soft_rst) |=> (tx_valid && $stable(tx_data)));
    // R9
    tx_busy_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (!sr1_q[S1_TXRDY] && !sr2_q[S2_TXDN]));
    // R7
    sr1_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr1_q[S1_DSENS] && sr1_q[S1_RTSST]));
endmodule

// File: rtl/uart_irq_comb.sv
// Interrupt combiner: masks the status words with their enables and ORs the
// result. Purely combinational; the clock feeds only the checker property.
module uart_irq_comb
    import uart_reg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  reg_word_t sr1,
    input  reg_word_t sr2,
    input  reg_word_t cr1,
    input  reg_word_t cr4,
    output logic      irq
);
    reg_word_t mask2;
    logic      term1, term2;

    // Purpose: build the status 2 enable mask and the two terms.
    always_comb begin
        mask2 = cr4 & C4_IRQ_MASK;
        mask2[S2_TXEMP] = cr1[C1_TXEIE];
        term1 = |(sr1 & cr1 & S1_IRQ_MASK);
        term2 = |(sr2 & mask2);
        irq   = term1 || term2;
    end

    // R10 R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cr1 & S1_IRQ_MASK) == '0 && !cr1[C1_TXEIE] && (cr4 & C4_IRQ_MASK) == '0) |-> !irq);
endmodule

// File: rtl/uart_reg_block.sv
// Top of the serial-port register block: host read multiplexer and the
// wiring of control, status and interrupt sub-blocks. Reads are
// combinational while rd_en is high; read side effects occur at the edge.
module uart_reg_block
    import uart_reg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_break,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              irq
);
    reg_word_t wr_word;
    logic      soft_rst;
    reg_word_t cr1_q, cr2_q, cr3_q, cr4_q, fcr_q, binc_q, bmod_q, bcnt_q, ms_q;
    reg_word_t sr1_q, sr2_q, tst_q, rxw_q;
    reg_word_t rd_word;
    logic      unused_hi;

    assign wr_word   = wr_data[REG_W-1:0];
    assign unused_hi = ^wr_data[DATA_W-1:REG_W];

    uart_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wr_word (wr_word),
        .soft_rst(soft_rst),
        .cr1_q   (cr1_q),
        .cr2_q   (cr2_q),
        .cr3_q   (cr3_q),
        .cr4_q   (cr4_q),
        .fcr_q   (fcr_q),
        .binc_q  (binc_q),
        .bmod_q  (bmod_q),
        .bcnt_q  (bcnt_q),
        .ms_q    (ms_q)
    );

    uart_status #(.CHAR_W(CHAR_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .reg_sel  (reg_sel),
        .wr_word  (wr_word),
        .tx_enable(cr2_q[C2_TXON]),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_break (rx_break),
        .rx_ready (rx_ready),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .sr1_q    (sr1_q),
        .sr2_q    (sr2_q),
        .tst_q    (tst_q),
        .rxw_q    (rxw_q)
    );

    uart_irq_comb u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .sr1  (sr1_q),
        .sr2  (sr2_q),
        .cr1  (cr1_q),
        .cr4  (cr4_q),
        .irq  (irq)
    );

    // Purpose: select the register addressed by the host read.
    always_comb begin
        rd_word = '0;
        unique case (reg_sel)
            IDX_RXD:  begin
                rd_word = rxw_q;
                rd_word[RW_VALID] = !tst_q[TS_RXEMP];
            end
            IDX_CR1:  rd_word = cr1_q;
            IDX_CR2:  rd_word = cr2_q;
            IDX_CR3:  rd_word = cr3_q;
            IDX_CR4:  rd_word = cr4_q;
            IDX_FCR:  rd_word = fcr_q;
            IDX_SR1:  rd_word = sr1_q;
            IDX_SR2:  rd_word = sr2_q;
            IDX_BINC: rd_word = binc_q;
            IDX_BMOD: rd_word = bmod_q;
            IDX_BCNT: rd_word = bcnt_q;
            IDX_MS:   rd_word = ms_q;
            IDX_TST:  rd_word = tst_q;
            default:  rd_word = '0;
        endcase
        rd_data = rd_en ? DATA_W'(rd_word) : '0;
    end

    // R9
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == IDX_TXD && !cr2_q[C2_TXON] && !tx_valid) |=> !tx_valid);
endmodule

// File: tb/uart_reg_block_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module uart_reg_block_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_sel = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_break = 1'b0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_reg_block u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_sel = idx; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_sel = idx; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] idx, input logic [31:0] exp);
        logic [31:0] v;
        rd(idx, v);
        check(req, v, exp);
    endtask

    task automatic rx_push(input logic [7:0] c, input logic brk);
        @(negedge clk);
        rx_data = c; rx_break = brk; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_break = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 sr1", 6'h25, 32'h6040);
        rd_chk("R1 sr2", 6'h26, 32'h4028);
        rd_chk("R1 test", 6'h2D, 32'h0060);
        rd_chk("R1 cr1", 6'h20, 32'h0000);
        rd_chk("R1 cr2", 6'h21, 32'h0001);
        rd_chk("R1 cr3", 6'h22, 32'h0700);
        rd_chk("R1 cr4", 6'h23, 32'h0000);
        rd_chk("R1 bmod", 6'h2A, 32'h0000);
        rd_chk("R1 bcnt", 6'h2B, 32'h0004);
        rd_chk("R1 rxw", 6'h00, 32'h4000);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
    endtask

    task automatic t_storage;
        wr(6'h22, 32'h1234_ABCD); rd_chk("R2 cr3", 6'h22, 32'h0000_ABCD);
        wr(6'h24, 32'hFFFF_0801); rd_chk("R2 fcr", 6'h24, 32'h0801);
        wr(6'h29, 32'h0000_00F0); rd_chk("R2 binc", 6'h29, 32'h00F0);
        wr(6'h2A, 32'h0000_1111); rd_chk("R2 bmod", 6'h2A, 32'h1111);
        wr(6'h2B, 32'h0000_2222); rd_chk("R2 bcnt", 6'h2B, 32'h2222);
        wr(6'h2C, 32'h0000_3333); rd_chk("R2 ms", 6'h2C, 32'h3333);
        wr(6'h2D, 32'h0000_FFFF); rd_chk("R2 test ignored", 6'h2D, 32'h0060);
        wr(6'h05, 32'h0000_FFFF); rd_chk("R2 unmapped", 6'h05, 32'h0);
        rd_chk("R2 unmapped no effect", 6'h25, 32'h6040);
    endtask

    task automatic t_irq_tx_side;
        wr(6'h20, 32'h2000); check("R10 trdy irq", {31'd0, irq}, 32'd1);
        wr(6'h20, 32'h0200); check("R10 rrdy idle", {31'd0, irq}, 32'd0);
        wr(6'h20, 32'h0040); check("R11 txfe irq", {31'd0, irq}, 32'd1);
        wr(6'h20, 32'h0000); check("R11 masked", {31'd0, irq}, 32'd0);
        wr(6'h23, 32'h0008); check("R11 txdc irq", {31'd0, irq}, 32'd1);
        wr(6'h23, 32'h0001); check("R11 rdr idle", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_receive;
        rx_push(8'h41, 1'b0);
        check("R4 rx_ready", {31'd0, rx_ready}, 32'd0);
        check("R11 rdr irq", {31'd0, irq}, 32'd1);
        rd_chk("R4 sr1", 6'h25, 32'h6240);
        rd_chk("R4 sr2", 6'h26, 32'h4029);
        rd_chk("R4 test", 6'h2D, 32'h0040);
        rx_push(8'h42, 1'b0);
        wr(6'h23, 32'h0000);
        wr(6'h20, 32'h0200);
        check("R10 rrdy irq", {31'd0, irq}, 32'd1);
        rd_chk("R5 full read", 6'h00, 32'h8041);
        check("R10 cleared", {31'd0, irq}, 32'd0);
        rd_chk("R5 sr1", 6'h25, 32'h6040);
        rd_chk("R5 test", 6'h2D, 32'h0060);
        rd_chk("R5 empty read", 6'h00, 32'h0041);
        rd_chk("R5 sr2", 6'h26, 32'h4028);
        wr(6'h20, 32'h0000);
    endtask

    task automatic t_break_w1c;
        rx_push(8'h00, 1'b1);
        rd_chk("R6 sr2", 6'h26, 32'h402D);
        rd_chk("R6 word", 6'h00, 32'hD800);
        wr(6'h26, 32'hFFFF);
        rd_chk("R8 sr2 cleared", 6'h26, 32'h4028);
        rx_push(8'h00, 1'b1);
        wr(6'h26, 32'h0004);
        rd_chk("R8 brkd only", 6'h26, 32'h4029);
        rd_chk("R6 pop", 6'h00, 32'hD800);
        wr(6'h25, 32'hFFFF);
        rd_chk("R7 sr1 kept", 6'h25, 32'h6040);
    endtask

    task automatic t_transmit;
        wr(6'h23, 32'h0008);
        wr(6'h10, 32'h0055);
        check("R9 disabled", {31'd0, tx_valid}, 32'd0);
        rd_chk("R9 sr1 idle", 6'h25, 32'h6040);
        wr(6'h21, 32'h0005);
        wr(6'h10, 32'h01A5);
        check("R9 valid", {31'd0, tx_valid}, 32'd1);
        check("R9 data", {24'd0, tx_data}, 32'h00A5);
        check("R11 txdc low", {31'd0, irq}, 32'd0);
        rd_chk("R9 sr1 busy", 6'h25, 32'h4040);
        rd_chk("R9 sr2 busy", 6'h26, 32'h4020);
        wr(6'h10, 32'h0033);
        check("R9 pending ignore", {24'd0, tx_data}, 32'h00A5);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        check("R9 done", {31'd0, tx_valid}, 32'd0);
        check("R11 txdc back", {31'd0, irq}, 32'd1);
        rd_chk("R9 sr1 ready", 6'h25, 32'h6040);
        rd_chk("R9 sr2 ready", 6'h26, 32'h4028);
    endtask

    task automatic t_soft_reset;
        wr(6'h20, 32'h1234);
        wr(6'h23, 32'h0009);
        rx_push(8'h77, 1'b0);
        wr(6'h10, 32'h0011);
        check("R3 pre pending", {31'd0, tx_valid}, 32'd1);
        wr(6'h21, 32'h0006);
        check("R3 tx dropped", {31'd0, tx_valid}, 32'd0);
        rd_chk("R3 cr2", 6'h21, 32'h0007);
        rd_chk("R3 cr1", 6'h20, 32'h0000);
        rd_chk("R3 cr3", 6'h22, 32'h0700);
        rd_chk("R3 bcnt", 6'h2B, 32'h0004);
        rd_chk("R3 sr1", 6'h25, 32'h6040);
        rd_chk("R3 sr2", 6'h26, 32'h4028);
        rd_chk("R3 rxw", 6'h00, 32'h4000);
        rd_chk("R3 cr4 kept", 6'h23, 32'h0009);
        rd_chk("R3 ms kept", 6'h2C, 32'h3333);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_storage();
        t_irq_tx_side();
        t_receive();
        t_break_w1c();
        t_transmit();
        t_soft_reset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule